// File: doc/BRIEF.md
# Droop Wake Pulse Generator

This block sits on the secondary side of an isolated supply. A comparator reports, one bit per clock, whether the winding-level signal is below its low threshold. A second comparator reports whether the bias rail has sagged below the last stored sample. The block qualifies long low intervals on the winding and turns the next rising edge into a power-cycle detect (PCD) event. That event re-phases the wake oscillator, tells the period counter that a cycle has passed, and asks the sample-and-hold to take a new supply sample.

While the rail is flagged as drooping, the block produces a periodic wake-drive enable: a short pulse at a fixed repetition rate, which the current source outside the block turns into current injected into the winding. The burst ends when a power cycle is detected. The block ignores the winding activity that its own pulses cause, by masking the comparator for the length of each pulse and one clock more. All timing constants are parameters counted in clock ticks.

Top module: `wake_droop_pulser`

## Requirements
- R1: Throughout reset and after it, with no stimulus, all four outputs stay low, and the detector starts unarmed.
- R2: After `wake_low_i` has been high for at least ARM_TICKS consecutive clocks, the first clock it reads low produces a one-cycle PCD pulse. The pulse appears two clocks after the first low sample.
- R3: A high run of `wake_low_i` shorter than ARM_TICKS produces no PCD. A single low clock restarts the qualifying count, so two short runs never add up.
- R4: `sample_vdd_o` and `osc_reset_o` are high in exactly the same cycle as `pcd_o`.
- R5: A PCD disarms the detector. Further PCDs need a new qualifying high run, so any further low after a PCD, or a short run after it, gives nothing.
- R6: Two clocks after `droop_i` is first seen high, `wake_drive_o` goes high for exactly PULSE_TICKS clocks.
- R7: While droop stays flagged and no PCD occurs, drive pulses start every PERIOD_TICKS clocks.
- R8: A PCD drops `wake_drive_o` in the cycle the PCD pulse is high and zeroes the oscillator phase. If `droop_i` is still high, a new full pulse starts on the next clock.
- R9: `wake_low_i` is ignored while a drive pulse is high and for one clock after it. During that time the qualifying count and the armed state are held, so an echo of the pulse on the input never yields a PCD.
- R10: After a PCD with `droop_i` low, no further drive pulses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wake_low_i | input | 1 | High while the winding signal is below the low threshold |
| droop_i | input | 1 | High while the rail is below the droop fraction of its last sample |
| pcd_o | output | 1 | One-cycle power-cycle-detect pulse |
| sample_vdd_o | output | 1 | One-cycle strobe asking for a new rail sample |
| osc_reset_o | output | 1 | One-cycle indication that the wake oscillator was re-phased |
| wake_drive_o | output | 1 | Enable for the wake current source |

## Verification
Each result has a fixed latency:

| Result | Due |
|---|---|
| PCD with its two companion strobes | Two clocks after the first low sample that follows a qualifying run |
| First drive pulse | Two clocks after droop rises |
| Later drive pulses | Every PERIOD_TICKS clocks |
| Falling edge of a pulse | PULSE_TICKS clocks after its rising edge |
| Restart pulse after a PCD with droop still high | One clock after the PCD |

The bench works out the due cycle of every event from these latencies when it applies the stimulus, and queues the events in cycle order. A monitor samples on the falling clock edge, turns each output edge into an event, and compares it against the head of the queue for both kind and cycle. Any event that arrives early, late or unrequested is therefore a failure, and so is anything still in the queue at the end.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

  // Width needed to hold values 0 .. n-1 (minimum one bit).
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/wdp_rst_sync.sv
module wdp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  // Asserts asynchronously, deasserts after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/wdp_arm_detect.sv
module wdp_arm_detect #(
  parameter int unsigned ARM_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_low_i,
  input  logic mask_i,
  output logic fire_o,
  output logic pcd_o
);
  localparam int unsigned CW = wdp_pkg::cnt_w(ARM_TICKS + 1);
  localparam logic [CW-1:0] ARM_LAST = CW'(ARM_TICKS - 1);

  logic          wl_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic          pcd_q;
  logic          fire;

  // A rise seen while armed and not masked is a power cycle.
  assign fire = armed_q & ~wl_q & ~mask_i;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (!mask_i) begin
      if (wl_q) begin
        if (cnt_q >= ARM_LAST) armed_d = 1'b1;
        else                   cnt_d   = cnt_q + 1'b1;
      end else begin
        cnt_d = '0;
        if (fire) armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_q    <= 1'b0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pcd_q   <= 1'b0;
    end else begin
      wl_q    <= wake_low_i;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      pcd_q   <= fire;
    end
  end

  assign fire_o = fire;
  assign pcd_o  = pcd_q;
endmodule

// File: rtl/wdp_wake_osc.sv
module wdp_wake_osc #(
  parameter int unsigned PULSE_TICKS  = 10,
  parameter int unsigned PERIOD_TICKS = 303
) (
  input  logic clk,
  input  logic rst_n,
  input  logic droop_i,
  input  logic fire_i,
  output logic drive_o,
  output logic mask_o
);
  // PULSE_TICKS must be below PERIOD_TICKS.
  localparam int unsigned PW = wdp_pkg::cnt_w(PERIOD_TICKS);
  localparam logic [PW-1:0] PH_LAST  = PW'(PERIOD_TICKS - 1);
  localparam logic [PW-1:0] PH_PULSE = PW'(PULSE_TICKS);

  logic          droop_q;
  logic          active_q, active_d;
  logic [PW-1:0] ph_q, ph_d;
  logic          drive_q, drive_d;
  logic          drive_d1_q;

  always_comb begin
    if (fire_i)       active_d = 1'b0;
    else if (droop_q) active_d = 1'b1;
    else              active_d = active_q;

    if (!active_d || !active_q) ph_d = '0;
    else if (ph_q == PH_LAST)   ph_d = '0;
    else                        ph_d = ph_q + 1'b1;

    drive_d = active_d && (ph_d < PH_PULSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      droop_q    <= 1'b0;
      active_q   <= 1'b0;
      ph_q       <= '0;
      drive_q    <= 1'b0;
      drive_d1_q <= 1'b0;
    end else begin
      droop_q    <= droop_i;
      active_q   <= active_d;
      ph_q       <= ph_d;
      drive_q    <= drive_d;
      drive_d1_q <= drive_q;
    end
  end

  assign drive_o = drive_q;
  assign mask_o  = drive_q | drive_d1_q;
endmodule

// File: rtl/wake_droop_pulser.sv
module wake_droop_pulser #(
  parameter int unsigned ARM_TICKS    = 5,
  parameter int unsigned PULSE_TICKS  = 10,
  parameter int unsigned PERIOD_TICKS = 303
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_low_i,
  input  logic droop_i,
  output logic pcd_o,
  output logic sample_vdd_o,
  output logic osc_reset_o,
  output logic wake_drive_o
);
  logic rst_sync_n;
  logic fire;
  logic mask;
  logic pcd;

  wdp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdp_arm_detect #(.ARM_TICKS(ARM_TICKS)) u_det (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wake_low_i (wake_low_i),
    .mask_i     (mask),
    .fire_o     (fire),
    .pcd_o      (pcd)
  );

  wdp_wake_osc #(.PULSE_TICKS(PULSE_TICKS), .PERIOD_TICKS(PERIOD_TICKS)) u_osc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .droop_i (droop_i),
    .fire_i  (fire),
    .drive_o (wake_drive_o),
    .mask_o  (mask)
  );

  // One event drives all three strobes.
  assign pcd_o        = pcd;
  assign sample_vdd_o = pcd;
  assign osc_reset_o  = pcd;
endmodule

// File: rtl/wdp_chk.sv
module wdp_chk #(
  parameter int unsigned PULSE_TICKS = 10
) (
  input logic clk,
  input logic rst_n,
  input logic wake_low_i,
  input logic droop_i,
  input logic pcd_o,
  input logic sample_vdd_o,
  input logic osc_reset_o,
  input logic wake_drive_o
);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hi_cnt <= '0;
    else if (wake_drive_o) hi_cnt <= hi_cnt + 1;
    else                   hi_cnt <= '0;
  end

  // R5
  pcd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcd_o |=> !pcd_o);

  // R2
  pcd_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcd_o |-> !$past(wake_low_i, 2));

  // R8
  pcd_stops_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcd_o |-> !wake_drive_o);

  // R6
  drive_needs_droop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_drive_o) |-> $past(droop_i, 2));

  // R6
  drive_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_drive_o |-> (hi_cnt < PULSE_TICKS));

  // R4
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_vdd_o) |-> osc_reset_o);
endmodule

bind wake_droop_pulser wdp_chk #(.PULSE_TICKS(PULSE_TICKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wake_low_i   (wake_low_i),
  .droop_i      (droop_i),
  .pcd_o        (pcd_o),
  .sample_vdd_o (sample_vdd_o),
  .osc_reset_o  (osc_reset_o),
  .wake_drive_o (wake_drive_o)
);

// File: tb/wake_droop_pulser_tb.sv
`timescale 1ns/1ps
module wake_droop_pulser_tb;
  localparam int ARM = 5;
  localparam int PUL = 10;
  localparam int PER = 303;
  localparam int EV_PCD = 0, EV_RISE = 1, EV_FALL = 2;

  typedef struct {int kind; int cyc; string tag;} ev_t;

  logic clk, rst_n, wl_drv, droop, echo_en;
  logic pcd, smp, oscr, drv;
  logic wake_low;
  int   cyc, n_chk, n_err;
  logic mon_on, prev_drv, done;
  ev_t  exp_q[$];

  assign wake_low = wl_drv | (echo_en & drv);

  wake_droop_pulser #(.ARM_TICKS(ARM), .PULSE_TICKS(PUL), .PERIOD_TICKS(PER)) u_dut (
    .clk(clk), .rst_n(rst_n), .wake_low_i(wake_low), .droop_i(droop),
    .pcd_o(pcd), .sample_vdd_o(smp), .osc_reset_o(oscr), .wake_drive_o(drv)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic expect_ev(input int kind, input int at, input string tag);
    ev_t e;
    e.kind = kind; e.cyc = at; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic hold_low(input int len);
    int c0;
    c0 = cyc;
    wl_drv = 1'b1;
    wait_until(c0 + len);
    wl_drv = 1'b0;
  endtask

  task automatic take(input int kind);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "unexpected event", kind, -1);
    end else begin
      e = exp_q.pop_front();
      chk(e.kind == kind, {e.tag, " kind"}, kind, e.kind);
      chk(e.cyc == cyc, {e.tag, " cycle"}, cyc, e.cyc);
    end
  endtask

  // Monitor: turns output edges into events and matches the queue.
  always @(negedge clk) begin
    if (mon_on) begin
      if (pcd | smp | oscr) begin
        // R4: all three strobes together
        chk(pcd & smp & oscr, "R4 strobes", {pcd, smp, oscr}, 7);
        take(EV_PCD);
      end
      if (drv && !prev_drv) take(EV_RISE);
      if (!drv && prev_drv) take(EV_FALL);
      prev_drv <= drv;
    end
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int c;
    cyc = 0; n_chk = 0; n_err = 0; done = 1'b0;
    mon_on = 1'b0; prev_drv = 1'b0;
    rst_n = 1'b0; wl_drv = 1'b0; droop = 1'b0; echo_en = 1'b0;
    repeat (4) @(negedge clk);
    // R1: outputs quiet in reset
    chk({pcd, smp, oscr, drv} == 4'b0, "R1 reset outputs", {pcd, smp, oscr, drv}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk({pcd, smp, oscr, drv} == 4'b0, "R1 after reset", {pcd, smp, oscr, drv}, 0);
    mon_on = 1'b1;
    repeat (10) @(negedge clk);   // R1: unarmed, no events allowed

    // R3: one short of qualifying
    hold_low(ARM - 1);
    repeat (10) @(negedge clk);
    // R3: split runs do not add up
    hold_low(3); @(negedge clk); hold_low(3);
    repeat (10) @(negedge clk);

    // R2: exact qualifying length
    c = cyc; expect_ev(EV_PCD, c + ARM + 2, "R2 min run");
    hold_low(ARM);
    repeat (10) @(negedge clk);
    // R2 long run, then R5 disarm: short run after PCD gives nothing
    c = cyc; expect_ev(EV_PCD, c + 20 + 2, "R2 long run");
    hold_low(20);
    repeat (5) @(negedge clk);
    hold_low(ARM - 1);
    repeat (10) @(negedge clk);

    // R6/R7/R9: droop burst with winding echo of each pulse
    c = cyc;
    expect_ev(EV_RISE, c + 2, "R6 first rise");
    expect_ev(EV_FALL, c + 2 + PUL, "R6 first fall");
    expect_ev(EV_RISE, c + 2 + PER, "R7 second rise");
    expect_ev(EV_FALL, c + 2 + PER + PUL, "R7 second fall");
    droop = 1'b1; echo_en = 1'b1;
    wait_until(c + 2 + PER + PUL + 5);
    // R9 would have produced PCDs on the echoes; now a real cycle, R10
    c = cyc; expect_ev(EV_PCD, c + 8 + 2, "R9 real cycle after echoes");
    hold_low(8);
    droop = 1'b0;
    repeat (400) @(negedge clk);   // R10: no further pulses

    // R8: PCD re-phases and restarts when droop persists
    c = cyc;
    expect_ev(EV_RISE, c + 2, "R8 burst rise");
    expect_ev(EV_FALL, c + 2 + PUL, "R8 burst fall");
    expect_ev(EV_PCD, c + 30, "R8 pcd");
    expect_ev(EV_RISE, c + 31, "R8 restart rise");
    expect_ev(EV_FALL, c + 31 + PUL, "R8 restart fall");
    expect_ev(EV_PCD, c + 141, "R10 final pcd");
    droop = 1'b1;
    wait_until(c + 20);
    hold_low(8);
    wait_until(c + 131);
    hold_low(8);
    droop = 1'b0;
    repeat (400) @(negedge clk);   // R10: stays off after PCD

    chk(exp_q.size() == 0, "all expected events seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule